// File: doc/BRIEF.md
# Low-Power Wake Pin Debouncer with Backup Wipe

This block watches two external wake or tamper pins. Each pin is first resynchronised, then counted on a slow sampling strobe that the surrounding chip supplies as a one-cycle enable. A pin that stays active for the programmed number of sampling periods produces a debounced event. The event sets a sticky per-pin status bit and raises a one-cycle wake request. If the mode word allows it, the event also zeroes the lower half of a small backup register file in the same clock edge.

All control comes from a single 32-bit mode word held elsewhere. Bits 5 and 6 attach pin 0 and pin 1 to the debouncer. Bit 7 arms the backup wipe. Bits 18:16 hold a period code. The backup file is written and read over a simple word port. The status bits are cleared by a write-one-to-clear strobe with a per-pin mask.

Top module: `lpdb_tamper_top`

## Requirements
- R1: A pin whose attach bit in the mode word (bit 5 for pin 0, bit 6 for pin 1) is 0 never produces an event, a status bit or a wake request.
- R2: A period code of 0 in mode word bits 18:16 disables both pins, however long they stay active.
- R3: A period code c from 1 to 7 produces an event once the pin has been seen active at c+1 consecutive sampling strobes. A strobe that sees the pin inactive restarts the count, and clock cycles without a strobe do not count. When the strobe is high every cycle, the status bit sets on the (c+3)-th rising clock edge after the pin rises, because of the two synchroniser stages.
- R4: One continuous active period gives at most one event. A further event requires at least one strobe that sees the pin inactive, followed by a full threshold again.
- R5: Each pin has a sticky status bit (bit 0 for pin 0, bit 1 for pin 1). It sets on that pin's event and clears only when the clear strobe is high with the matching mask bit. A new event in the same cycle wins over the clear.
- R6: Any event raises wake_o for exactly one cycle, on the same edge that sets the status bit. Events from both pins on the same edge give a single pulse.
- R7: When mode bit 7 is 1, an event zeroes backup words 0 to 3 on the edge that sets the status bit, and words 4 to 7 are kept. When bit 7 is 0, the backup contents do not change.
- R8: A backup write to words 0 to 3 on the wiping edge is lost. A write to words 4 to 7 on that edge takes effect.
- R9: After reset, both status bits are 0, wake_o is 0 and all eight backup words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sampling strobe, one cycle per sampling period |
| pin_raw | input | 2 | Asynchronous wake pins, active high |
| mode_word | input | 32 | Mode word: attach bits 6:5, wipe enable bit 7, period code 18:16 |
| bk_wr_en | input | 1 | Backup word write strobe |
| bk_addr | input | 3 | Backup word index for write and read |
| bk_wdata | input | 32 | Backup write data |
| bk_rdata | output | 32 | Backup word at bk_addr, combinational |
| st_clr_wr | input | 1 | Status clear strobe |
| st_clr_mask | input | 2 | Per-pin clear mask, 1 clears |
| evt_status | output | 2 | Sticky debounced-event status per pin |
| wake_o | output | 1 | One-cycle wake request |

## Verification
Two functions can land on the same clock edge: a debounced event that wipes the lower backup words, and a bus write to the backup file. The bench sets the period code to 1 with a strobe every cycle, so the firing edge is known exactly. It then presents a write on that edge, once to word 2 and once to word 5. The write to word 2 must read back as zero, and the write to word 5 must read back as the written data. The same reasoning covers an event that coincides with a status clear, which must leave the status bit set.

// File: rtl/lpdb_pkg.sv
package lpdb_pkg;
    // Mode word field positions; the debouncer decodes these directly
    localparam int MODE_W   = 32;
    localparam int EN_LSB   = 5;
    localparam int WIPE_BIT = 7;
    localparam int CODE_LSB = 16;
    localparam int CODE_W   = 3;
    // Threshold is code+1, so one extra bit covers the largest value
    localparam int CNT_W    = CODE_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } pin_st_t;

    function automatic logic [CNT_W-1:0] thr_of(input logic [CODE_W-1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction
endpackage

// File: rtl/lpdb_sync.sv
module lpdb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/lpdb_pin_cnt.sv
module lpdb_pin_cnt
    import lpdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              active_i,
    input  logic              enable_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              fire_o
);
    pin_st_t          st_d, st_q;
    logic [CNT_W-1:0] thr, nxt;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        thr    = thr_of(code_i);
        nxt    = st_q.cnt + CNT_W'(1);
        if (!enable_i || code_i == '0) begin
            st_d = '{cnt: '0, armed: 1'b1};
        end else if (tick_i) begin
            if (!active_i) begin
                // inactive sample restarts the count and re-arms
                st_d = '{cnt: '0, armed: 1'b1};
            end else if (st_q.armed) begin
                if (nxt >= thr) begin
                    fire_o = 1'b1;
                    st_d   = '{cnt: '0, armed: 1'b0};
                end else begin
                    st_d.cnt = nxt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, armed: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lpdb_backup.sv
module lpdb_backup #(
    parameter int WORDS = 8,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wipe,
    output logic [WORDS-1:0][DW-1:0] words_o
);
    localparam int HALF = WORDS / 2;

    logic [WORDS-1:0][DW-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        if (wr_en) words_d[wr_addr] = wr_data;
        // wipe is applied after the write so it wins on the lower half
        if (wipe) begin
            for (int i = 0; i < HALF; i++) words_d[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) words_q <= '0;
        else        words_q <= words_d;
    end

    assign words_o = words_q;
endmodule

// File: rtl/lpdb_tamper_top.sv
module lpdb_tamper_top
    import lpdb_pkg::*;
#(
    parameter int N_PINS = 2,
    parameter int WORDS  = 8,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_tick,
    input  logic [N_PINS-1:0]        pin_raw,
    input  logic [MODE_W-1:0]        mode_word,
    input  logic                     bk_wr_en,
    input  logic [$clog2(WORDS)-1:0] bk_addr,
    input  logic [DW-1:0]            bk_wdata,
    output logic [DW-1:0]            bk_rdata,
    input  logic                     st_clr_wr,
    input  logic [N_PINS-1:0]        st_clr_mask,
    output logic [N_PINS-1:0]        evt_status,
    output logic                     wake_o
);
    typedef struct packed {
        logic [N_PINS-1:0] status;
        logic              wake;
    } top_st_t;

    top_st_t                  st_d, st_q;
    logic [N_PINS-1:0]        pin_sync;
    logic [N_PINS-1:0]        fire;
    logic                     wipe;
    logic [WORDS-1:0][DW-1:0] words_flat;
    logic                     unused_mode;

    assign unused_mode = ^mode_word;

    lpdb_sync #(.W(N_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_sync)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        lpdb_pin_cnt u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (smp_tick),
            .active_i (pin_sync[p]),
            .enable_i (mode_word[EN_LSB+p]),
            .code_i   (mode_word[CODE_LSB +: CODE_W]),
            .fire_o   (fire[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (st_clr_wr) st_d.status = st_q.status & ~st_clr_mask;
        st_d.status = st_d.status | fire;   // new event beats the clear
        st_d.wake   = |fire;
        wipe        = (|fire) & mode_word[WIPE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lpdb_backup #(.WORDS(WORDS), .DW(DW)) u_backup (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bk_wr_en),
        .wr_addr (bk_addr),
        .wr_data (bk_wdata),
        .wipe    (wipe),
        .words_o (words_flat)
    );

    assign bk_rdata   = words_flat[bk_addr];
    assign evt_status = st_q.status;
    assign wake_o     = st_q.wake;
endmodule

// File: rtl/lpdb_tamper_chk.sv
module lpdb_tamper_chk
    import lpdb_pkg::*;
#(
    parameter int N_PINS = 2,
    parameter int WORDS  = 8,
    parameter int DW     = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [MODE_W-1:0]        mode_word,
    input logic                     st_clr_wr,
    input logic [N_PINS-1:0]        st_clr_mask,
    input logic [N_PINS-1:0]        evt_status,
    input logic                     wake_o,
    input logic [WORDS-1:0][DW-1:0] words_flat
);
    localparam int HALF = WORDS / 2;

    logic unused_chk;
    assign unused_chk = ^mode_word;

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (evt_status == '0 && !wake_o));

    // R6
    wake_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (|evt_status));

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin_chk
        // R1 R2
        rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_status[p]) |->
                ($past(mode_word[EN_LSB+p]) && $past(mode_word[CODE_LSB +: CODE_W]) != '0));

        // R5
        fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(evt_status[p]) |-> $past(st_clr_wr && st_clr_mask[p]));

        // R6
        rise_gives_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_status[p]) |-> wake_o);
    end

    for (genvar w = 0; w < HALF; w++) begin : g_wipe_chk
        // R7
        wipe_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_o && $past(mode_word[WIPE_BIT])) |-> (words_flat[w] == '0));
    end
endmodule

bind lpdb_tamper_top lpdb_tamper_chk #(
    .N_PINS (N_PINS),
    .WORDS  (WORDS),
    .DW     (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_word   (mode_word),
    .st_clr_wr   (st_clr_wr),
    .st_clr_mask (st_clr_mask),
    .evt_status  (evt_status),
    .wake_o      (wake_o),
    .words_flat  (words_flat)
);

// File: tb/tb_lpdb_tamper_top.sv
module tb_lpdb_tamper_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_tick = 1'b1;
    logic [1:0]  pin_raw = '0;
    logic [31:0] mode_word = '0;
    logic        bk_wr_en = 1'b0;
    logic [2:0]  bk_addr = '0;
    logic [31:0] bk_wdata = '0;
    logic [31:0] bk_rdata;
    logic        st_clr_wr = 1'b0;
    logic [1:0]  st_clr_mask = '0;
    logic [1:0]  evt_status;
    logic        wake_o;

    int errs = 0;
    int checks = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    lpdb_tamper_top dut (
        .clk (clk), .rst_n (rst_n), .smp_tick (smp_tick), .pin_raw (pin_raw),
        .mode_word (mode_word), .bk_wr_en (bk_wr_en), .bk_addr (bk_addr),
        .bk_wdata (bk_wdata), .bk_rdata (bk_rdata), .st_clr_wr (st_clr_wr),
        .st_clr_mask (st_clr_mask), .evt_status (evt_status), .wake_o (wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (wake_o) wake_cnt++;

    typedef struct packed {
        logic [2:0] code;
        logic [1:0] en;
        logic       wipe;
        logic [1:0] pin;
        logic [7:0] len;
        logic [1:0] exp_evt;
        logic [1:0] exp_wake;
    } vec_t;

    // code, attach, wipe, pins driven, active cycles, expected status, wake pulses
    localparam vec_t VECS [10] = '{
        '{3'd1, 2'b01, 1'b0, 2'b01, 8'd3,  2'b01, 2'd1},  // R3 above threshold
        '{3'd1, 2'b01, 1'b0, 2'b01, 8'd1,  2'b00, 2'd0},  // R3 one short
        '{3'd7, 2'b01, 1'b0, 2'b01, 8'd8,  2'b01, 2'd1},  // R3 largest code, exact
        '{3'd7, 2'b01, 1'b0, 2'b01, 8'd7,  2'b00, 2'd0},  // R3 largest code, one short
        '{3'd0, 2'b11, 1'b1, 2'b11, 8'd20, 2'b00, 2'd0},  // R2 code zero
        '{3'd3, 2'b01, 1'b1, 2'b10, 8'd20, 2'b00, 2'd0},  // R1 pin 1 detached
        '{3'd3, 2'b11, 1'b1, 2'b10, 8'd10, 2'b10, 2'd1},  // R7 wipe on pin 1
        '{3'd2, 2'b11, 1'b1, 2'b01, 8'd2,  2'b00, 2'd0},  // R7 no event, no wipe
        '{3'd1, 2'b11, 1'b0, 2'b11, 8'd30, 2'b11, 2'd1},  // R4 R6 long pulse, both pins
        '{3'd4, 2'b10, 1'b1, 2'b10, 8'd5,  2'b10, 2'd1}   // R3 R7 exact threshold
    };

    function automatic logic [31:0] mk_mode(input logic [1:0] en, input logic wp,
                                            input logic [2:0] code);
        return (32'(en) << 5) | (32'(wp) << 7) | (32'(code) << 16);
    endfunction

    function automatic logic [31:0] pat(input int k, input int w);
        return 32'h5A5A_0000 + 32'(k << 8) + 32'(w);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input int a, input logic [31:0] d);
        bk_wr_en = 1'b1; bk_addr = 3'(a); bk_wdata = d;
        step(1);
        bk_wr_en = 1'b0;
    endtask

    task automatic rd_word(input int a, output logic [31:0] d);
        bk_addr = 3'(a);
        #1;
        d = bk_rdata;
    endtask

    task automatic clr_status(input logic [1:0] m);
        st_clr_wr = 1'b1; st_clr_mask = m;
        step(1);
        st_clr_wr = 1'b0; st_clr_mask = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R9 reset state
        check("R9 status", 32'(evt_status), 32'd0);
        check("R9 wake", 32'(wake_o), 32'd0);
        rd_word(0, rd); check("R9 word0", rd, 32'd0);
        rd_word(7, rd); check("R9 word7", rd, 32'd0);

        // vector table
        foreach (VECS[k]) begin
            for (int w = 0; w < 8; w++) wr_word(w, pat(k, w));
            clr_status(2'b11);
            mode_word = mk_mode(VECS[k].en, VECS[k].wipe, VECS[k].code);
            step(2);
            wake_cnt = 0;
            pin_raw = VECS[k].pin;
            step(int'(VECS[k].len));
            pin_raw = '0;
            step(8);
            check($sformatf("R1 R2 R3 vec%0d status", k), 32'(evt_status), 32'(VECS[k].exp_evt));
            check($sformatf("R4 R6 vec%0d wake pulses", k), 32'(wake_cnt), 32'(VECS[k].exp_wake));
            rd_word(0, rd);
            check($sformatf("R7 vec%0d word0", k), rd,
                  (VECS[k].wipe && VECS[k].exp_evt != 0) ? 32'd0 : pat(k, 0));
            rd_word(4, rd);
            check($sformatf("R7 vec%0d word4", k), rd, pat(k, 4));
        end

        // R3 exact edge: code 1 fires on the 4th edge after the pin rises
        clr_status(2'b11);
        mode_word = mk_mode(2'b01, 1'b0, 3'd1);
        step(2);
        pin_raw = 2'b01;
        step(3);
        check("R3 not yet at edge 3", 32'(evt_status), 32'd0);
        step(1);
        check("R3 set at edge 4", 32'(evt_status), 32'd1);
        check("R6 wake on setting edge", 32'(wake_o), 32'd1);
        step(1);
        check("R6 wake one cycle", 32'(wake_o), 32'd0);
        check("R5 sticky", 32'(evt_status), 32'd1);
        // R5 mask selects the pin
        clr_status(2'b10);
        check("R5 other mask keeps", 32'(evt_status), 32'd1);
        clr_status(2'b01);
        check("R5 cleared", 32'(evt_status), 32'd0);
        // R4 still held: no second event
        step(10);
        check("R4 held no re-fire", 32'(evt_status), 32'd0);
        pin_raw = 2'b00;
        step(4);
        pin_raw = 2'b01;
        step(6);
        check("R4 re-armed event", 32'(evt_status), 32'd1);
        pin_raw = 2'b00;
        step(4);

        // R3 only strobes count
        clr_status(2'b11);
        smp_tick = 1'b0;
        pin_raw = 2'b01;
        step(20);
        check("R3 no strobe no count", 32'(evt_status), 32'd0);
        smp_tick = 1'b1; step(1); smp_tick = 1'b0;
        step(5);
        check("R3 one strobe short", 32'(evt_status), 32'd0);
        smp_tick = 1'b1; step(1); smp_tick = 1'b0;
        step(1);
        check("R3 second strobe fires", 32'(evt_status), 32'd1);
        smp_tick = 1'b1;
        pin_raw = 2'b00;
        step(4);

        // R5 event beats a clear on the same edge
        clr_status(2'b11);
        pin_raw = 2'b01;
        step(3);
        st_clr_wr = 1'b1; st_clr_mask = 2'b01;
        step(1);
        st_clr_wr = 1'b0; st_clr_mask = '0;
        check("R5 set wins over clear", 32'(evt_status), 32'd1);
        pin_raw = 2'b00;
        step(4);

        // R8 write to low half on the wiping edge is lost
        for (int w = 0; w < 8; w++) wr_word(w, pat(20, w));
        clr_status(2'b11);
        mode_word = mk_mode(2'b01, 1'b1, 3'd1);
        step(2);
        pin_raw = 2'b01;
        step(3);
        wr_word(2, 32'hDEAD_BEEF);
        rd_word(2, rd); check("R8 low write lost", rd, 32'd0);
        rd_word(6, rd); check("R7 upper kept", rd, pat(20, 6));
        pin_raw = 2'b00;
        step(4);

        // R8 write to upper half on the wiping edge lands
        for (int w = 0; w < 8; w++) wr_word(w, pat(21, w));
        clr_status(2'b11);
        step(1);
        pin_raw = 2'b01;
        step(3);
        wr_word(5, 32'hCAFE_F00D);
        rd_word(5, rd); check("R8 upper write lands", rd, 32'hCAFE_F00D);
        rd_word(1, rd); check("R7 low wiped", rd, 32'd0);
        pin_raw = 2'b00;
        step(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule